// File: doc/BRIEF.md
# LVDS Panel Bit Mapper

The block takes one parallel pixel per clock, meaning 8-bit red, green and blue plus horizontal sync, vertical sync and data-enable. From each pixel it builds the 7-bit words that an external 7:1 serializer shifts onto the data lanes of an LVDS panel link. It also emits the fixed 7-bit pattern for the link's clock lane in every pixel period. The words come out one register stage after the pixel enters.

Two panel bit-layout conventions are available, selected by a mode bit: "NS" and "JEIDA". A width bit selects between two link formats:

- 24-bit colour on four data lanes.
- 18-bit colour on three data lanes, with the fourth lane idle.

Several settings let the same core fit different board layouts:

- Each of the three sync/enable signals can be inverted before it is packed into the words.
- A selection field decides which logical lane drives each physical lane.
- A per-lane invert bit compensates for swapped P/N wiring.

All settings are captured only when a frame begins, so a panel never sees its lane content change partway through a frame.

Top module: `lvds_panel_mapper`

## Requirements
- R1: While reset is high, all lane words and the clock word are 0. From the first clock after reset, the clock word equals 7'b1100011 in every cycle.
- R2: In NS mode with 24-bit width, word bits are numbered 0 to 6 as follows. Lane 0 bits 0-5 carry R[0..5] and bit 6 carries G[0]. Lane 1 bits 0-4 carry G[1..5] and bits 5-6 carry B[0..1]. Lane 2 bits 0-3 carry B[2..5], with bit 4 = HS, bit 5 = VS and bit 6 = DE. Lane 3 bits 0-1 carry R[6..7], bits 2-3 carry G[6..7], bits 4-5 carry B[6..7], and bit 6 is 0.
- R3: In JEIDA mode with 24-bit width, lanes 0-2 hold the same positions, but each colour contribution is taken from bits [7:2] of its component instead of [5:0]. Lane 3 carries bits [1:0] of R, G and B in bit pairs 0-1, 2-3 and 4-5, and bit 6 is 0.
- R4: With 18-bit width (width bit 0), lanes 0-2 carry bits [7:2] of each component in the JEIDA positions for either mode bit. Logical lane 3 is all zeros.
- R5: Each of HS, VS and DE is XORed with its own invert bit before packing.
- R6: Physical lane p carries logical lane cfg_lane_sel[2p+1:2p]. Physical lane p occupies lane_word_o[7p+6:7p].
- R7: When cfg_lane_inv[p] is 1, every bit of physical lane p is inverted after routing. This includes an idle lane.
- R8: The configuration is loaded only in a cycle where pix_vs is 1 and was 0 in the previous cycle. It applies to the pixel of that cycle and to all later pixels until the next such cycle. Configuration changes at any other time have no effect on the outputs.
- R9: After reset, before any frame start, the block uses NS mode, 24-bit width, no sync inversion, identity lane order (cfg_lane_sel = 8'hE4) and no lane inversion.
- R10: A pixel sampled at clock edge k appears on lane_word_o after edge k, with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_r | input | 8 | Red component |
| pix_g | input | 8 | Green component |
| pix_b | input | 8 | Blue component |
| pix_hs | input | 1 | Horizontal sync, active high at source |
| pix_vs | input | 1 | Vertical sync, active high at source; its rising edge starts a frame |
| pix_de | input | 1 | Data enable |
| cfg_jeida | input | 1 | 0 = NS layout, 1 = JEIDA layout |
| cfg_wide | input | 1 | 1 = 24-bit on four lanes, 0 = 18-bit on three lanes |
| cfg_hs_inv | input | 1 | Invert HS before packing |
| cfg_vs_inv | input | 1 | Invert VS before packing |
| cfg_de_inv | input | 1 | Invert DE before packing |
| cfg_lane_sel | input | 8 | Logical lane source for each physical lane, 2 bits per lane |
| cfg_lane_inv | input | 4 | Per physical lane bit inversion |
| lane_word_o | output | 28 | Four 7-bit physical lane words |
| clk_word_o | output | 7 | Clock-lane 7-bit pattern |

## Verification
The bench targets these corner cases:

- **Configuration change with VS held high.** A mapper that tracked the live configuration would change its output mid-frame here.
- **Falling edge of VS.** A design that loaded settings on any VS transition would reload on this edge.
- **First pixel of a frame.** A design that registered the settings one cycle late would show the stale layout on exactly this pixel.
- **18-bit mode in NS setting.** A design that ignored the width for the bit offset would put the low colour bits on the panel.
- **18-bit mode with the idle lane inverted.** A design that applied inversion before the idle forcing would output zeros on that lane instead of all ones.
- **Non-identity lane orders and mixed inversion.** These expose swapped index or bit ordering.

// File: rtl/lvds_map_pkg.sv
package lvds_map_pkg;

    localparam int NUM_LANES = 4;
    localparam int WORD_W    = 7;
    localparam int COMP_W    = 8;
    localparam int SEL_W     = $clog2(NUM_LANES);
    localparam int MAIN_W    = 6;
    localparam int EXTRA_W   = COMP_W - MAIN_W;

    typedef enum logic {
        MAP_NS    = 1'b0,
        MAP_JEIDA = 1'b1
    } map_e;

    typedef logic [NUM_LANES-1:0][WORD_W-1:0] lane_arr_t;
    typedef logic [NUM_LANES-1:0][SEL_W-1:0]  lane_sel_t;

    typedef struct packed {
        logic [COMP_W-1:0] r;
        logic [COMP_W-1:0] g;
        logic [COMP_W-1:0] b;
        logic              hs;
        logic              vs;
        logic              de;
    } pix_t;

    typedef struct packed {
        map_e                 layout;
        logic                 wide;
        logic                 hs_inv;
        logic                 vs_inv;
        logic                 de_inv;
        lane_sel_t            lane_sel;
        logic [NUM_LANES-1:0] lane_inv;
    } cfg_t;

    function automatic lane_sel_t identity_sel();
        lane_sel_t s;
        for (int i = 0; i < NUM_LANES; i++) begin
            s[i] = SEL_W'(i);
        end
        return s;
    endfunction

    localparam cfg_t CFG_DEFAULT = '{
        layout:   MAP_NS,
        wide:     1'b1,
        hs_inv:   1'b0,
        vs_inv:   1'b0,
        de_inv:   1'b0,
        lane_sel: identity_sel(),
        lane_inv: '0
    };

    // Six bits of a component that ride on lanes 0-2
    function automatic logic [MAIN_W-1:0] main_bits(input logic [COMP_W-1:0] c,
                                                    input logic upper);
        return upper ? c[COMP_W-1:EXTRA_W] : c[MAIN_W-1:0];
    endfunction

    // Two bits of a component that ride on lane 3
    function automatic logic [EXTRA_W-1:0] extra_bits(input logic [COMP_W-1:0] c,
                                                      input logic upper);
        return upper ? c[EXTRA_W-1:0] : c[COMP_W-1:MAIN_W];
    endfunction

endpackage

// File: rtl/lvds_cfg_shadow.sv
module lvds_cfg_shadow
    import lvds_map_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic vsync_i,
    input  cfg_t cfg_i,
    output cfg_t cfg_o
);

    logic vs_q;
    cfg_t shadow_q;
    logic frame_start;

    assign frame_start = vsync_i & ~vs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vs_q     <= 1'b0;
            shadow_q <= CFG_DEFAULT;
        end else begin
            vs_q <= vsync_i;
            if (frame_start) begin
                shadow_q <= cfg_i;
            end
        end
    end

    // The frame-start pixel already uses the fresh settings
    assign cfg_o = frame_start ? cfg_i : shadow_q;

    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(shadow_q));

    p_cfg_load_r8: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (shadow_q == $past(cfg_i)));

endmodule

// File: rtl/lvds_bit_pack.sv
module lvds_bit_pack
    import lvds_map_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pix_t      pix_i,
    input  cfg_t      cfg_i,
    output lane_arr_t words_o
);

    logic               upper;
    logic [MAIN_W-1:0]  r_main, g_main, b_main;
    logic [EXTRA_W-1:0] r_ext, g_ext, b_ext;
    logic               hs_p, vs_p, de_p;

    // 18-bit panels take the top six bits regardless of layout
    assign upper = (cfg_i.layout == MAP_JEIDA) || !cfg_i.wide;

    assign r_main = main_bits(pix_i.r, upper);
    assign g_main = main_bits(pix_i.g, upper);
    assign b_main = main_bits(pix_i.b, upper);
    assign r_ext  = extra_bits(pix_i.r, upper);
    assign g_ext  = extra_bits(pix_i.g, upper);
    assign b_ext  = extra_bits(pix_i.b, upper);

    assign hs_p = pix_i.hs ^ cfg_i.hs_inv;
    assign vs_p = pix_i.vs ^ cfg_i.vs_inv;
    assign de_p = pix_i.de ^ cfg_i.de_inv;

    always_comb begin
        words_o[0] = {g_main[0], r_main};
        words_o[1] = {b_main[1:0], g_main[MAIN_W-1:1]};
        words_o[2] = {de_p, vs_p, hs_p, b_main[MAIN_W-1:2]};
        words_o[3] = cfg_i.wide ? {1'b0, b_ext, g_ext, r_ext} : '0;
    end

    p_idle_lane_r4: assert property (@(posedge clk) disable iff (rst)
        !cfg_i.wide |-> (words_o[3] == '0));

    p_reserved_bit_r2: assert property (@(posedge clk) disable iff (rst)
        cfg_i.wide |-> (words_o[3][WORD_W-1] == 1'b0));

endmodule

// File: rtl/lvds_lane_route.sv
module lvds_lane_route
    import lvds_map_pkg::*;
(
    input  lane_arr_t            logical_i,
    input  lane_sel_t            sel_i,
    input  logic [NUM_LANES-1:0] inv_i,
    output lane_arr_t            physical_o
);

    for (genvar p = 0; p < NUM_LANES; p++) begin : g_lane
        assign physical_o[p] = logical_i[sel_i[p]] ^ {WORD_W{inv_i[p]}};
    end

endmodule

// File: rtl/lvds_panel_mapper.sv
module lvds_panel_mapper
    import lvds_map_pkg::*;
#(
    parameter logic [WORD_W-1:0] CLK_PATTERN = 7'b1100011
)(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [COMP_W-1:0]           pix_r,
    input  logic [COMP_W-1:0]           pix_g,
    input  logic [COMP_W-1:0]           pix_b,
    input  logic                        pix_hs,
    input  logic                        pix_vs,
    input  logic                        pix_de,
    input  logic                        cfg_jeida,
    input  logic                        cfg_wide,
    input  logic                        cfg_hs_inv,
    input  logic                        cfg_vs_inv,
    input  logic                        cfg_de_inv,
    input  logic [NUM_LANES*SEL_W-1:0]  cfg_lane_sel,
    input  logic [NUM_LANES-1:0]        cfg_lane_inv,
    output logic [NUM_LANES*WORD_W-1:0] lane_word_o,
    output logic [WORD_W-1:0]           clk_word_o
);

    pix_t      pix;
    cfg_t      cfg_in;
    cfg_t      cfg_eff;
    lane_arr_t logical_w;
    lane_arr_t physical_w;
    lane_arr_t lane_q;
    logic [WORD_W-1:0] clk_q;

    assign pix = '{r: pix_r, g: pix_g, b: pix_b,
                   hs: pix_hs, vs: pix_vs, de: pix_de};

    assign cfg_in = '{layout:   map_e'(cfg_jeida),
                      wide:     cfg_wide,
                      hs_inv:   cfg_hs_inv,
                      vs_inv:   cfg_vs_inv,
                      de_inv:   cfg_de_inv,
                      lane_sel: cfg_lane_sel,
                      lane_inv: cfg_lane_inv};

    lvds_cfg_shadow u_shadow (
        .clk     (clk),
        .rst     (rst),
        .vsync_i (pix_vs),
        .cfg_i   (cfg_in),
        .cfg_o   (cfg_eff)
    );

    lvds_bit_pack u_pack (
        .clk     (clk),
        .rst     (rst),
        .pix_i   (pix),
        .cfg_i   (cfg_eff),
        .words_o (logical_w)
    );

    lvds_lane_route u_route (
        .logical_i  (logical_w),
        .sel_i      (cfg_eff.lane_sel),
        .inv_i      (cfg_eff.lane_inv),
        .physical_o (physical_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lane_q <= '0;
            clk_q  <= '0;
        end else begin
            lane_q <= physical_w;
            clk_q  <= CLK_PATTERN;
        end
    end

    assign lane_word_o = lane_q;
    assign clk_word_o  = clk_q;

    p_clk_pattern_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (clk_word_o == CLK_PATTERN));

    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (lane_word_o == '0 && clk_word_o == '0));

endmodule

// File: tb/lvds_panel_mapper_tb.sv
module lvds_panel_mapper_tb;

    typedef struct packed {
        logic       jeida;
        logic       wide;
        logic       hsi;
        logic       vsi;
        logic       dei;
        logic [7:0] sel;
        logic [3:0] inv;
    } tcfg_t;

    typedef struct packed {
        tcfg_t      c;
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
        logic       hs;
        logic       de;
        logic [3:0] req;
    } vec_t;

    // c{jeida,wide,hsi,vsi,dei,sel,inv}, r, g, b, hs, de, requirement
    localparam vec_t VECS [8] = '{
        '{'{1'b0,1'b1,1'b0,1'b0,1'b0,8'hE4,4'h0}, 8'h5A, 8'hC3, 8'h96, 1'b1, 1'b1, 4'd2}, // R2
        '{'{1'b1,1'b1,1'b0,1'b0,1'b0,8'hE4,4'h0}, 8'h5A, 8'hC3, 8'h96, 1'b1, 1'b1, 4'd3}, // R3
        '{'{1'b0,1'b0,1'b0,1'b0,1'b0,8'hE4,4'h0}, 8'h3C, 8'hA5, 8'h0F, 1'b0, 1'b1, 4'd4}, // R4
        '{'{1'b1,1'b0,1'b0,1'b0,1'b0,8'hE4,4'h0}, 8'hF1, 8'h2E, 8'h7B, 1'b1, 1'b0, 4'd4}, // R4
        '{'{1'b0,1'b1,1'b1,1'b1,1'b1,8'hE4,4'h0}, 8'h81, 8'h42, 8'h24, 1'b0, 1'b1, 4'd5}, // R5
        '{'{1'b0,1'b1,1'b0,1'b0,1'b0,8'h1B,4'h0}, 8'hE7, 8'h18, 8'hA9, 1'b1, 1'b1, 4'd6}, // R6
        '{'{1'b0,1'b1,1'b0,1'b0,1'b0,8'hE4,4'hA}, 8'h6D, 8'hB2, 8'h5C, 1'b0, 1'b1, 4'd7}, // R7
        '{'{1'b1,1'b1,1'b1,1'b0,1'b0,8'h4E,4'h5}, 8'h99, 8'h66, 8'hF0, 1'b1, 1'b0, 4'd6}  // R6, R7
    };

    localparam tcfg_t DEF_CFG = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'hE4, 4'h0};
    localparam logic [6:0] CLK_PAT = 7'b1100011;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  pix_r = '0, pix_g = '0, pix_b = '0;
    logic        pix_hs = 1'b0, pix_vs = 1'b0, pix_de = 1'b0;
    tcfg_t       cfg = '0;
    logic [27:0] lane_word_o;
    logic [6:0]  clk_word_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    lvds_panel_mapper u_dut (
        .clk          (clk),
        .rst          (rst),
        .pix_r        (pix_r),
        .pix_g        (pix_g),
        .pix_b        (pix_b),
        .pix_hs       (pix_hs),
        .pix_vs       (pix_vs),
        .pix_de       (pix_de),
        .cfg_jeida    (cfg.jeida),
        .cfg_wide     (cfg.wide),
        .cfg_hs_inv   (cfg.hsi),
        .cfg_vs_inv   (cfg.vsi),
        .cfg_de_inv   (cfg.dei),
        .cfg_lane_sel (cfg.sel),
        .cfg_lane_inv (cfg.inv),
        .lane_word_o  (lane_word_o),
        .clk_word_o   (clk_word_o)
    );

    // Reference mapping written bit by bit from the requirements
    function automatic logic [27:0] model(input tcfg_t c, input logic [7:0] r, g, b,
                                          input logic hs, vs, de);
        logic [3:0][6:0] lw;
        logic [27:0] o;
        int s, lb;
        lw = '0;
        s  = (c.jeida || !c.wide) ? 2 : 0;
        for (int i = 0; i < 6; i++) lw[0][i] = r[i+s];
        lw[0][6] = g[s];
        for (int i = 0; i < 5; i++) lw[1][i] = g[i+1+s];
        lw[1][5] = b[s];
        lw[1][6] = b[s+1];
        for (int i = 0; i < 4; i++) lw[2][i] = b[i+2+s];
        lw[2][4] = hs ^ c.hsi;
        lw[2][5] = vs ^ c.vsi;
        lw[2][6] = de ^ c.dei;
        if (c.wide) begin
            lb = c.jeida ? 0 : 6;
            lw[3][0] = r[lb]; lw[3][1] = r[lb+1];
            lw[3][2] = g[lb]; lw[3][3] = g[lb+1];
            lw[3][4] = b[lb]; lw[3][5] = b[lb+1];
        end
        for (int p = 0; p < 4; p++)
            o[p*7 +: 7] = lw[c.sel[p*2 +: 2]] ^ {7{c.inv[p]}};
        return o;
    endfunction

    task automatic check(input string req, input logic [27:0] got, input logic [27:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic set_pix(input logic [7:0] r, g, b, input logic hs, vs, de);
        pix_r = r; pix_g = g; pix_b = b;
        pix_hs = hs; pix_vs = vs; pix_de = de;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        tcfg_t cfg_a, cfg_b;
        logic [27:0] exp;

        // R1: reset state
        @(negedge clk);
        set_pix(8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b0, 1'b1);
        tick();
        tick();
        check("R1 reset lanes", lane_word_o, 28'h0);
        check("R1 reset clock word", {21'h0, clk_word_o}, 28'h0);

        // R9: defaults hold after reset with no frame start, whatever cfg says
        cfg = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h1B, 4'hF};
        set_pix(8'h5A, 8'hC3, 8'h96, 1'b1, 1'b0, 1'b1);
        rst = 1'b0;
        tick();
        check("R9 defaults", lane_word_o, model(DEF_CFG, 8'h5A, 8'hC3, 8'h96, 1'b1, 1'b0, 1'b1));
        check("R1 clock pattern", {21'h0, clk_word_o}, {21'h0, CLK_PAT});

        // R10: one-cycle latency, pixel changes each cycle
        set_pix(8'h12, 8'h34, 8'h56, 1'b0, 1'b0, 1'b1);
        tick();
        check("R10 latency", lane_word_o, model(DEF_CFG, 8'h12, 8'h34, 8'h56, 1'b0, 1'b0, 1'b1));

        // Table walk: each vector starts a frame, then its first pixel is checked
        foreach (VECS[i]) begin
            set_pix(8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
            tick();
            cfg = VECS[i].c;
            set_pix(VECS[i].r, VECS[i].g, VECS[i].b, VECS[i].hs, 1'b1, VECS[i].de);
            tick();
            exp = model(VECS[i].c, VECS[i].r, VECS[i].g, VECS[i].b, VECS[i].hs, 1'b1, VECS[i].de);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), lane_word_o, exp);
            check("R1 clock pattern", {21'h0, clk_word_o}, {21'h0, CLK_PAT});
        end

        // R8: configuration change mid-frame (VS held high) is ignored
        cfg_a = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'hE4, 4'h0};
        cfg_b = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'h39, 4'hC};
        set_pix(8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
        tick();
        cfg = cfg_a;
        set_pix(8'hA1, 8'hB2, 8'hC3, 1'b0, 1'b1, 1'b1);
        tick();
        check("R8 frame start load", lane_word_o, model(cfg_a, 8'hA1, 8'hB2, 8'hC3, 1'b0, 1'b1, 1'b1));
        cfg = cfg_b;
        set_pix(8'h3D, 8'h4E, 8'h5F, 1'b1, 1'b1, 1'b1);
        tick();
        check("R8 mid-frame change ignored", lane_word_o, model(cfg_a, 8'h3D, 8'h4E, 8'h5F, 1'b1, 1'b1, 1'b1));
        // VS falling edge must not load either
        set_pix(8'h77, 8'h88, 8'h99, 1'b0, 1'b0, 1'b1);
        tick();
        check("R8 falling edge ignored", lane_word_o, model(cfg_a, 8'h77, 8'h88, 8'h99, 1'b0, 1'b0, 1'b1));
        // Next rising edge applies the pending settings to that very pixel
        set_pix(8'h0C, 8'hF3, 8'h6A, 1'b1, 1'b1, 1'b0);
        tick();
        check("R8 next frame start", lane_word_o, model(cfg_b, 8'h0C, 8'hF3, 8'h6A, 1'b1, 1'b1, 1'b0));

        // R4 and R7: 18-bit idle lane with inversion reads all ones
        set_pix(8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
        tick();
        cfg = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hE4, 4'h8};
        set_pix(8'hFF, 8'h00, 8'hFF, 1'b0, 1'b1, 1'b0);
        tick();
        check("R7 inverted idle lane", {21'h0, lane_word_o[27:21]}, 28'h000007F);
        check("R4 18-bit lanes", {7'h0, lane_word_o[20:0]},
              {7'h0, model(cfg, 8'hFF, 8'h00, 8'hFF, 1'b0, 1'b1, 1'b0)} & 28'h01FFFFF);

        // R2: reserved bit of lane 3 stays 0 even with all-ones colour
        set_pix(8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
        tick();
        cfg = DEF_CFG;
        set_pix(8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1);
        tick();
        check("R2 reserved bit", {21'h0, lane_word_o[27:21]}, 28'h000003F);

        // R1: synchronous reset mid-run clears outputs
        rst = 1'b1;
        tick();
        check("R1 reset mid-run", {clk_word_o, lane_word_o[20:0]}, 28'h0);
        rst = 1'b0;
        tick();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule